// File: doc/BRIEF.md
# Serial Result Framer for a Successive-Approximation Converter

This block sends a converter's result over a three-wire serial link while the conversion is still running. A free-running phase counter divides the master clock into a serial clock. A framing strobe pulls low for one 16-period frame. The data line carries two leading zeros and then the result bits, most significant first. Each result bit comes straight from the successive-approximation register as soon as that register settles it. No finished word is stored and shifted. The block holds one pending decision and puts it on the line at the next serial rising edge.

All three lines are open-drain. For each line a `*_dl` output of 1 pulls the line low, and 0 releases it to the weak pull-up, which reads as 1. `sclk_en` tells whether the clock line is being driven. A mode input either keeps the serial clock driven at all times or releases it between frames, so several converters can share one serial bus.

The controller has four states:
- **IDLE**: no frame is in progress.
- **ARMED**: a start has been seen and the block is waiting for the next serial rising edge.
- **LEAD**: the leading zeros are being sent.
- **RESULT**: the decision bits are being sent.

The transitions are:
- **open**: IDLE or ARMED goes to LEAD on a serial rising edge.
- **arm**: IDLE goes to ARMED when a start arrives off a rising edge.
- **lead done**: LEAD goes to RESULT after the last zero slot.
- **frame end**: RESULT goes to IDLE after slot 15.

Top module: `serial_result_framer`

## Requirements
- R1: Each frame has 16 serial periods. Slots 0 and 1 carry 0. Slots 2 to 15 carry the 14 decisions in the order they were decided, so the MSB is in slot 2.
- R2: The data line changes only at a serial rising edge, which is the master edge where the serial clock goes high. It holds for the whole serial period, so it is stable at the falling edge, where it is sampled.
- R3: The serial period is 2*SCLK_HALF master cycles. The clock is high for the first SCLK_HALF cycles after each rising edge. The phase counter restarts at reset, and the first master edge after reset release brings phase 1.
- R4: A start sampled on the master edge that is itself a serial rising edge pulls the strobe low at that edge. A start sampled on any other edge pulls it low at the next serial rising edge. The strobe then stays low for exactly 16 serial periods and rises at a serial rising edge.
- R5: A start sampled while the block is not in IDLE is ignored. The frame length and content do not change, and no second frame follows.
- R6: A decision sampled on any master edge of slot k, after the edge that opens slot k and up to and including the edge that closes it, appears on the data line in slot k+1. The SAR gives exactly one decision in each of slots 1 to 14.
- R7: With `sclk_cont`=1 the serial clock is always driven (`sclk_en`=1) and keeps toggling. With `sclk_cont`=0 it is driven only while the strobe is low. Otherwise `sclk_en`=0 and `sclk_dl`=0.
- R8: Outside a frame the data and strobe lines are released (`sdata_dl`=0, `sstrb_dl`=0).
- R9: During reset the strobe and data are released and the serial clock level is high (`sclk_dl`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; the serial clock is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Conversion start pulse |
| sar_valid | input | 1 | A SAR decision is present this cycle |
| sar_bit | input | 1 | Value of that decision |
| sclk_cont | input | 1 | 1: serial clock always driven; 0: released between frames |
| sclk_en | output | 1 | Serial clock line is driven |
| sclk_dl | output | 1 | Pull serial clock line low |
| sdata_dl | output | 1 | Pull data line low |
| sstrb_dl | output | 1 | Pull frame strobe line low |

## Verification
A SAR decision can arrive on the same master edge as a serial rising edge. In that cycle the bit that closes one slot must also be the bit that feeds the next slot. The bench sweeps the decision offset across every phase of the slot, including the closing edge. For each offset it rebuilds the 16-bit word from falling-edge samples and compares it with the zero-padded result.

The start pulse is swept across every serial phase in the same way. This covers the case where a start lands on a rising edge and the frame must open at once. The bench judges the strobe's falling cycle against a delay it works out from the phase.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LEAD   = 2'd2,
        ST_RESULT = 2'd3
    } ssf_state_e;
endpackage

// File: rtl/ssf_phase_gen.sv
// Free-running serial clock phase generator derived from the master clock.
module ssf_phase_gen #(
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rise_next,
    output logic level
);
    localparam int PERIOD = 2 * SCLK_HALF;
    localparam int PW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] LAST   = PW'(PERIOD - 1);
    localparam logic [PW-1:0] HALF_V = PW'(SCLK_HALF);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    // The next master edge is a serial rising edge.
    assign rise_next = (phase_q == LAST);
    assign level     = (phase_q < HALF_V);

    p_phase_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_next |=> (phase_q == '0));
    p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_next |=> (phase_q == $past(phase_q) + 1'b1));
endmodule

// File: rtl/ssf_bit_latch.sv
// One-bit holding stage between SAR decisions and the serial data register.
module ssf_bit_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic capture_en,
    input  logic consume,
    input  logic sar_valid,
    input  logic sar_bit,
    output logic bit_out
);
    logic hold_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (clear || consume) begin
            pend_q <= 1'b0;
        end else if (capture_en && sar_valid) begin
            hold_q <= sar_bit;
            pend_q <= 1'b1;
        end
    end

    // A decision on the consuming edge bypasses the hold register.
    assign bit_out = (consume && sar_valid) ? sar_bit : hold_q;

    p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (pend_q || sar_valid));
    p_one_per_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && sar_valid && !clear) |-> !pend_q);
endmodule

// File: rtl/serial_result_framer.sv
module serial_result_framer #(
    parameter int RES_W     = 14,
    parameter int LEAD_N    = 2,
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start,
    input  logic sar_valid,
    input  logic sar_bit,
    input  logic sclk_cont,
    output logic sclk_en,
    output logic sclk_dl,
    output logic sdata_dl,
    output logic sstrb_dl
);
    import ssf_pkg::*;

    localparam int FRAME = RES_W + LEAD_N;
    localparam int SW    = $clog2(FRAME);
    localparam logic [SW-1:0] SLOT_LAST = SW'(FRAME - 1);
    localparam logic [SW-1:0] LEAD_LAST = SW'(LEAD_N - 1);

    ssf_state_e    state_q, state_d;
    logic [SW-1:0] slot_q, slot_d;
    logic          sdata_q, sdata_d;
    logic          rise_next, level;
    logic          consume, clear_lat, lat_bit, active;

    ssf_phase_gen #(.SCLK_HALF(SCLK_HALF)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_next (rise_next),
        .level     (level)
    );

    assign active = (state_q == ST_LEAD) || (state_q == ST_RESULT);

    ssf_bit_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_lat),
        .capture_en (active),
        .consume    (consume),
        .sar_valid  (sar_valid),
        .sar_bit    (sar_bit),
        .bit_out    (lat_bit)
    );

    // Next-state and slot logic
    always_comb begin
        state_d   = state_q;
        slot_d    = slot_q;
        sdata_d   = sdata_q;
        consume   = 1'b0;
        clear_lat = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_start) begin
                    if (rise_next) begin
                        state_d   = ST_LEAD;
                        slot_d    = '0;
                        sdata_d   = 1'b0;
                        clear_lat = 1'b1;
                    end else begin
                        state_d = ST_ARMED;
                    end
                end
            end
            ST_ARMED: begin
                if (rise_next) begin
                    state_d   = ST_LEAD;
                    slot_d    = '0;
                    sdata_d   = 1'b0;
                    clear_lat = 1'b1;
                end
            end
            ST_LEAD: begin
                if (rise_next) begin
                    slot_d = slot_q + 1'b1;
                    if (slot_q == LEAD_LAST) begin
                        state_d = ST_RESULT;
                        consume = 1'b1;
                        sdata_d = lat_bit;
                    end
                end
            end
            ST_RESULT: begin
                if (rise_next) begin
                    if (slot_q == SLOT_LAST) begin
                        state_d = ST_IDLE;
                        slot_d  = '0;
                        sdata_d = 1'b0;
                    end else begin
                        slot_d  = slot_q + 1'b1;
                        consume = 1'b1;
                        sdata_d = lat_bit;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            sdata_q <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            sdata_q <= sdata_d;
        end
    end

    // Open-drain outputs: 1 pulls the line low
    always_comb begin
        sstrb_dl = active;
        sdata_dl = active && !sdata_q;
        sclk_en  = sclk_cont || active;
        sclk_dl  = sclk_en && !level;
    end

    p_lead_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |-> sdata_dl);
    p_data_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_dl) |-> $past(rise_next));
    p_strobe_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sstrb_dl) |-> $past(rise_next));
    p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sstrb_dl) |-> ($past(slot_q) == SLOT_LAST));
    p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && conv_start && !rise_next) |=> ($stable(state_q) && $stable(slot_q)));
endmodule

// File: tb/tb_serial_result_framer.sv
module tb_serial_result_framer;
    localparam int HALF = 2;
    localparam int P    = 2 * HALF;
    localparam int FR   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic sar_valid = 1'b0;
    logic sar_bit = 1'b0;
    logic sclk_cont = 1'b0;
    logic sclk_en, sclk_dl, sdata_dl, sstrb_dl;

    int checks = 0;
    int failures = 0;
    int bph = 0;
    bit done = 1'b0;

    serial_result_framer #(.RES_W(14), .LEAD_N(2), .SCLK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
        .sar_valid(sar_valid), .sar_bit(sar_bit), .sclk_cont(sclk_cont),
        .sclk_en(sclk_en), .sclk_dl(sclk_dl), .sdata_dl(sdata_dl), .sstrb_dl(sstrb_dl)
    );

    always #10 clk = ~clk;

    // Bench model of the serial phase (R3)
    always @(posedge clk) begin
        if (!rst_n) bph <= 0;
        else        bph <= (bph == P - 1) ? 0 : bph + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle();
        chk(sstrb_dl == 1'b0, "R8 strobe released", sstrb_dl, 0);
        chk(sdata_dl == 1'b0, "R8 data released", sdata_dl, 0);
        if (sclk_cont) begin
            chk(sclk_en == 1'b1, "R7 continuous clock driven", sclk_en, 1);
            chk(!sclk_dl == (bph < HALF), "R7 continuous clock level", !sclk_dl, (bph < HALF));
        end else begin
            chk(sclk_en == 1'b0 && sclk_dl == 1'b0, "R7 gated clock released", {sclk_en, sclk_dl}, 0);
        end
    endtask

    task automatic run_frame(input logic [13:0] w, input int b, input int off, input bit cont, input bit dbl);
        logic [15:0] got;
        got = '0;
        sclk_cont = cont;
        @(negedge clk);
        check_idle();
        while (bph != b) begin
            @(negedge clk);
            check_idle();
        end
        conv_start = 1'b1;
        // R4: strobe falls P-b negedges after the start is driven
        for (int d = 1; d < P - b; d++) begin
            @(negedge clk);
            conv_start = 1'b0;
            chk(sstrb_dl == 1'b0, "R4 strobe still high before open", sstrb_dl, 0);
        end
        for (int t = 0; t <= FR * P; t++) begin
            int s;
            int n;
            @(negedge clk);
            s = t / P;
            n = t % P;
            chk(sstrb_dl == (t < FR * P), "R4 strobe window", sstrb_dl, (t < FR * P));
            if (t < FR * P) begin
                logic expb;
                expb = (s < 2) ? 1'b0 : w[15 - s];
                chk(!sclk_dl == (n < HALF), "R3 serial clock level", !sclk_dl, (n < HALF));
                chk(sclk_en == 1'b1, "R7 clock driven in frame", sclk_en, 1);
                chk(!sdata_dl == expb, "R2 data held over period", !sdata_dl, expb);
                if (n == HALF) got[15 - s] = !sdata_dl;
            end else begin
                chk(got == {2'b00, w}, "R1 R6 frame word", got, {2'b00, w});
                check_idle();
            end
            conv_start = dbl && (t == 5 * P + 1);   // R5 start during frame
            if (s >= 1 && s <= 14 && n == off) begin
                sar_valid = 1'b1;
                sar_bit   = w[14 - s];
            end else begin
                sar_valid = 1'b0;
            end
        end
        conv_start = 1'b0;
        sar_valid  = 1'b0;
        // R5: no second frame follows an ignored start
        for (int i = 0; i < 2 * P; i++) begin
            @(negedge clk);
            chk(sstrb_dl == 1'b0, "R5 no extra frame", sstrb_dl, 0);
            check_idle();
        end
    endtask

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk(sstrb_dl == 1'b0, "R9 reset strobe", sstrb_dl, 0);
        chk(sdata_dl == 1'b0, "R9 reset data", sdata_dl, 0);
        chk(sclk_dl == 1'b0, "R9 reset clock high", sclk_dl, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sclk_dl == 1'b1 && bph == 1, "R3 phase after reset", bph, 1);
        for (int k = 0; k < 8; k++) begin
            logic [13:0] w;
            case (k)
                0: w = 14'h0000;
                1: w = 14'h3FFF;
                2: w = 14'h2000;
                3: w = 14'h1FFF;
                default: w = 14'((k * 14'h1357) ^ 14'h0A5C);
            endcase
            for (int b = 0; b < P; b++)
                for (int off = 0; off < P; off++)
                    for (int c = 0; c < 2; c++)
                        run_frame(w, b, off, c[0], (off == 1));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule